// File: doc/BRIEF.md
# Boot-Aware Memory Address Decoder

This block sits between a 32-bit processor and three memory targets. The first is a byte-wide boot ROM. The second is a narrow RAM window on an 8-bit external backplane. The third is a 16 MB static RAM built from four byte-wide chips, one chip per byte lane. In every memory cycle the block looks at the address and the byte enables and picks exactly one target. It then drives that target's active-low select. For narrow targets it also asks the processor for 8-bit bus sizing, so that wide transfers are split into byte cycles.

The boot ROM only stays mapped while it is needed. After reset it answers the processor's first fetch at the top of the 4 GB space. It also answers the far-jump area at the top of the first megabyte. A write to I/O control port 28h removes the ROM from the map. From then on, those addresses fall through to the onboard RAM, which holds a copy of the ROM made by the boot code. Each further write to that port flips the mapping again.

While the ROM is being accessed, the block pulls a phantom line low so that no backplane memory drives the bus. A low-memory backplane window and a video carve-out in the first megabyte are sent to the backplane. Their bounds are parameters.

Top module: `mem_route_dec`

## Requirements
- R1: While `rst_n` is low, the ROM mapping is enabled. After reset, a memory cycle at FFFFFFF0h drives `rom_sel_n` low.
- R2: While the ROM mapping is enabled, addresses F0000h to FFFFFh and FFFE0000h to FFFFFFFFh select the ROM, whatever the byte enables. The address just below each of these ranges does not select the ROM.
- R3: `io_wr` high at a rising edge with `addr[15:0]` equal to 0028h toggles the ROM mapping from the next cycle. The first such write after reset disables the mapping, and the next one enables it again.
- R4: An `io_wr` pulse to any other 16-bit port value (for example 0029h or 0128h) leaves the ROM mapping unchanged. So does a clock edge with `io_wr` low.
- R5: `phantom_n` is low exactly in the cycles where `rom_sel_n` is low.
- R6: With the ROM not selected, addresses 0h to FFFFh (default window of 64 KB) drive `bp_sel_n` low. Address 10000h does not.
- R7: With the ROM not selected, the carve-out A0000h to C7FFFh drives `bp_sel_n` low. 9FFFFh and C8000h do not.
- R8: Every other memory-cycle address selects onboard RAM, with the upper address bits aliased and ROM addresses included when the mapping is off. `sram_cs_n[i]` is low exactly when `be_n[i]` is low, for lanes i = 0 to 3.
- R9: `size8_n` is low exactly when the ROM or the backplane is selected. For onboard RAM cycles it stays high.
- R10: When `mem_cyc` is low, all selects, `size8_n` and `phantom_n` are high. At most one of ROM, backplane and onboard RAM is selected in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the ROM mapping state |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_cyc | input | 1 | High while the processor runs a memory cycle |
| addr | input | 32 | Memory address; bits 15:0 carry the I/O port on I/O cycles |
| be_n | input | 4 | Byte enables, active low, one per lane |
| io_wr | input | 1 | I/O write strobe, active high |
| rom_sel_n | output | 1 | Boot ROM select, active low |
| bp_sel_n | output | 1 | Backplane RAM window select, active low |
| sram_cs_n | output | 4 | Onboard RAM chip selects, one per byte lane, active low |
| size8_n | output | 1 | 8-bit bus-size request to the processor, active low |
| phantom_n | output | 1 | Backplane phantom line, active low |

## Verification
The assertions assume that `io_wr` and `mem_cyc` are never high in the same cycle. The ROM toggle and the memory decode are taken to be separate bus phases. The assertions also assume that inputs change only away from the rising clock edge. The bench keeps to both rules: it drives everything at the falling edge, and it lowers `mem_cyc` in every cycle where it raises `io_wr`. The byte enables may take any pattern, including all lanes off. The lane assertion therefore only requires that no chip select appears on a disabled lane.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_ROM  = 2'd1,
      TGT_BP   = 2'd2,
      TGT_SRAM = 2'd3
   } tgt_e;
endpackage

// File: rtl/mrd_span_hit.sv
module mrd_span_hit #(
   parameter int               AW = 32,
   parameter logic [AW:0]      LO = '0,
   parameter logic [AW:0]      HI = '0,
   parameter bit               EN = 1'b1
) (
   input  logic [AW-1:0] a,
   output logic          hit
);
   logic [AW:0] a_ext;

   if (LO > HI) begin : g_bad_span
      $error("mrd_span_hit: LO above HI");
   end

   assign a_ext = {1'b0, a};
   assign hit   = EN && (a_ext >= LO) && (a_ext < HI);
endmodule

// File: rtl/mrd_rom_latch.sv
module mrd_rom_latch #(
   parameter int              IO_AW = 16,
   parameter logic [IO_AW-1:0] PORT = 16'h0028
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             io_wr,
   input  logic [IO_AW-1:0] io_addr,
   output logic             rom_on
);
   logic ctl_hit;

   assign ctl_hit = io_wr && (io_addr == PORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rom_on <= 1'b1;
      else if (ctl_hit) rom_on <= ~rom_on;
   end

   // R3: a control-port write flips the mapping
   p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hit |=> (rom_on != $past(rom_on)));

   // R4: without a control-port write the mapping holds
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_hit |=> $stable(rom_on));
endmodule

// File: rtl/mrd_route.sv
module mrd_route
   import mrd_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             mem_cyc,
   input  logic             rom_on,
   input  logic             rom_hit,
   input  logic             bp_hit,
   input  logic [LANES-1:0] be_n,
   output logic             rom_sel_n,
   output logic             bp_sel_n,
   output logic [LANES-1:0] sram_cs_n,
   output logic             size8_n,
   output logic             phantom_n
);
   tgt_e tgt;

   always_comb begin
      if (!mem_cyc)               tgt = TGT_NONE;
      else if (rom_on && rom_hit) tgt = TGT_ROM;
      else if (bp_hit)            tgt = TGT_BP;
      else                        tgt = TGT_SRAM;
   end

   assign rom_sel_n = (tgt != TGT_ROM);
   assign bp_sel_n  = (tgt != TGT_BP);
   assign phantom_n = (tgt != TGT_ROM);
   assign size8_n   = !((tgt == TGT_ROM) || (tgt == TGT_BP));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign sram_cs_n[g] = !((tgt == TGT_SRAM) && !be_n[g]);
   end
endmodule

// File: rtl/mem_route_dec.sv
module mem_route_dec #(
   parameter int                  ADDR_W       = 32,
   parameter int                  LANES        = 4,
   parameter int                  SRAM_AW      = 24,
   parameter int                  IO_AW        = 16,
   parameter logic [IO_AW-1:0]    CTRL_PORT    = 16'h0028,
   parameter logic [ADDR_W:0]     BP_WIN_LIMIT = 33'h0_0001_0000,
   parameter bit                  CARVE_EN     = 1'b1,
   parameter logic [ADDR_W:0]     CARVE_LO     = 33'h0_000A_0000,
   parameter logic [ADDR_W:0]     CARVE_HI     = 33'h0_000C_8000,
   parameter logic [ADDR_W:0]     LO_ROM_LO    = 33'h0_000F_0000,
   parameter logic [ADDR_W:0]     LO_ROM_HI    = 33'h0_0010_0000,
   parameter logic [ADDR_W:0]     HI_ROM_LO    = 33'h0_FFFE_0000,
   parameter logic [ADDR_W:0]     HI_ROM_HI    = 33'h1_0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_cyc,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  be_n,
   input  logic              io_wr,
   output logic              rom_sel_n,
   output logic              bp_sel_n,
   output logic [LANES-1:0]  sram_cs_n,
   output logic              size8_n,
   output logic              phantom_n
);
   localparam logic [ADDR_W:0] SRAM_BYTES = 33'(1) << SRAM_AW;
   localparam logic [ADDR_W:0] FIRST_MB   = 33'h0_0010_0000;

   if (BP_WIN_LIMIT > SRAM_BYTES) begin : g_chk_win
      $error("mem_route_dec: backplane window larger than RAM span");
   end
   if (CARVE_EN && (CARVE_HI > FIRST_MB)) begin : g_chk_carve
      $error("mem_route_dec: carve-out must lie in the first megabyte");
   end
   if (IO_AW > ADDR_W || LANES < 1) begin : g_chk_shape
      $error("mem_route_dec: bad port or lane shape");
   end

   logic rom_on;
   logic hi_rom_hit, lo_rom_hit, win_hit, carve_hit;

   mrd_rom_latch #(.IO_AW(IO_AW), .PORT(CTRL_PORT)) u_latch (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr),
      .io_addr(addr[IO_AW-1:0]), .rom_on(rom_on));

   mrd_span_hit #(.AW(ADDR_W), .LO(HI_ROM_LO), .HI(HI_ROM_HI)) u_hi_rom (
      .a(addr), .hit(hi_rom_hit));

   mrd_span_hit #(.AW(ADDR_W), .LO(LO_ROM_LO), .HI(LO_ROM_HI)) u_lo_rom (
      .a(addr), .hit(lo_rom_hit));

   mrd_span_hit #(.AW(ADDR_W), .LO(CARVE_LO), .HI(CARVE_HI), .EN(CARVE_EN)) u_carve (
      .a(addr), .hit(carve_hit));

   if (BP_WIN_LIMIT == '0) begin : g_no_win
      assign win_hit = 1'b0;
   end else begin : g_win
      mrd_span_hit #(.AW(ADDR_W), .LO('0), .HI(BP_WIN_LIMIT)) u_win (
         .a(addr), .hit(win_hit));
   end

   mrd_route #(.LANES(LANES)) u_route (
      .mem_cyc(mem_cyc), .rom_on(rom_on),
      .rom_hit(hi_rom_hit | lo_rom_hit), .bp_hit(win_hit | carve_hit),
      .be_n(be_n), .rom_sel_n(rom_sel_n), .bp_sel_n(bp_sel_n),
      .sram_cs_n(sram_cs_n), .size8_n(size8_n), .phantom_n(phantom_n));

   logic sram_any;
   assign sram_any = ~&sram_cs_n;

   // R10: never two targets at once
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~rom_sel_n, ~bp_sel_n, sram_any}));

   // R10: quiet outside memory cycles
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cyc |-> (rom_sel_n && bp_sel_n && !sram_any && size8_n && phantom_n));

   // R5: phantom tracks the ROM select
   p_phantom_r5: assert property (@(posedge clk) disable iff (!rst_n)
      phantom_n == rom_sel_n);

   // R9: narrow targets request 8-bit sizing, onboard RAM never does
   p_size8_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!size8_n) == (!rom_sel_n || !bp_sel_n));

   // R8: no chip select on a disabled lane
   p_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((~sram_cs_n) & be_n) == '0);
endmodule

// File: tb/sim_mem_route_dec.sv
module sim_mem_route_dec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_cyc = 1'b0;
   logic [31:0] addr = '0;
   logic [3:0]  be_n = 4'hF;
   logic        io_wr = 1'b0;
   logic        rom_sel_n, bp_sel_n, size8_n, phantom_n;
   logic [3:0]  sram_cs_n;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   mem_route_dec u0 (
      .clk(clk), .rst_n(rst_n), .mem_cyc(mem_cyc), .addr(addr), .be_n(be_n),
      .io_wr(io_wr), .rom_sel_n(rom_sel_n), .bp_sel_n(bp_sel_n),
      .sram_cs_n(sram_cs_n), .size8_n(size8_n), .phantom_n(phantom_n));

   // packed view: {rom_sel_n, bp_sel_n, sram_cs_n[3:0], size8_n, phantom_n}
   localparam logic [7:0] E_IDLE = 8'b11_1111_11;
   localparam logic [7:0] E_ROM  = 8'b01_1111_00;
   localparam logic [7:0] E_BP   = 8'b10_1111_01;

   function automatic logic [7:0] e_sram(input logic [3:0] be);
      return {2'b11, be, 2'b11};
   endfunction

   task automatic check(input string tag, input logic [7:0] exp);
      logic [7:0] got;
      got = {rom_sel_n, bp_sel_n, sram_cs_n, size8_n, phantom_n};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s addr=%h got=%b exp=%b", tag, addr, got, exp);
      end
   endtask

   task automatic mem(input logic [31:0] a, input logic [3:0] be);
      @(negedge clk);
      io_wr = 1'b0; mem_cyc = 1'b1; addr = a; be_n = be;
      #1;
   endtask

   task automatic iowr(input logic [15:0] port);
      @(negedge clk);
      mem_cyc = 1'b0; io_wr = 1'b1; addr = {16'hABCD, port}; be_n = 4'h0;
      #1;
      check("R10 idle during io write", E_IDLE);
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic t_reset;
      mem(32'hFFFF_FFF0, 4'h0);
      check("R1 reset fetch", E_ROM);
      check("R5 phantom with rom", E_ROM);
   endtask

   task automatic t_rom_ranges;
      mem(32'h000F_F000, 4'hE); check("R2 far jump", E_ROM);
      mem(32'h000F_0000, 4'h0); check("R2 low rom base", E_ROM);
      mem(32'h000E_FFFF, 4'hD); check("R2 below low rom", e_sram(4'hD));
      mem(32'hFFFE_0000, 4'h0); check("R2 high rom base", E_ROM);
      mem(32'hFFFD_FFFF, 4'h7); check("R2 below high rom", e_sram(4'h7));
   endtask

   task automatic t_backplane;
      mem(32'h0000_0000, 4'h0); check("R6 window base", E_BP);
      mem(32'h0000_FFFF, 4'hE); check("R6 window top R9", E_BP);
      mem(32'h0001_0000, 4'h0); check("R6 past window", e_sram(4'h0));
      mem(32'h0009_FFFF, 4'h3); check("R7 below carve", e_sram(4'h3));
      mem(32'h000A_0000, 4'h0); check("R7 carve base", E_BP);
      mem(32'h000C_7FFF, 4'h0); check("R7 carve top", E_BP);
      mem(32'h000C_8000, 4'hB); check("R7 past carve", e_sram(4'hB));
   endtask

   task automatic t_sram_lanes;
      for (int i = 0; i < 16; i++) begin
         mem(32'h0040_0000 + 32'(i * 4), 4'(i));
         check("R8 lane pattern", e_sram(4'(i)));
      end
      mem(32'h7F20_0000, 4'hA); check("R8 alias high", e_sram(4'hA));
   endtask

   task automatic t_idle;
      @(negedge clk);
      mem_cyc = 1'b0; addr = 32'hFFFF_FFF0; be_n = 4'h0;
      #1; check("R10 idle rom addr", E_IDLE);
      addr = 32'h0000_1000; #1; check("R10 idle bp addr", E_IDLE);
      addr = 32'h0020_0000; #1; check("R10 idle sram addr", E_IDLE);
   endtask

   task automatic t_other_ports;
      iowr(16'h0029);
      iowr(16'h0128);
      repeat (3) @(negedge clk);
      mem(32'hFFFF_FFF0, 4'h0); check("R4 other ports keep rom", E_ROM);
   endtask

   task automatic t_toggle;
      iowr(16'h0028);
      mem(32'hFFFF_FFF0, 4'h0); check("R3 first write shadows rom", e_sram(4'h0));
      mem(32'h000F_F000, 4'hC); check("R3 far jump now sram", e_sram(4'hC));
      iowr(16'h0028);
      mem(32'hFFFF_FFF0, 4'h0); check("R3 second write restores", E_ROM);
      iowr(16'h0028);
      mem(32'hFFFE_0000, 4'h5); check("R3 third write shadows", e_sram(4'h5));
      mem(32'h0000_8000, 4'h0); check("R6 window with rom off", E_BP);
   endtask

   task automatic t_reset_again;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      mem(32'hFFFF_FFF0, 4'h0); check("R1 reset re-enables rom", E_ROM);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_rom_ranges;
      t_backplane;
      t_sram_lanes;
      t_idle;
      t_other_ports;
      t_toggle;
      t_reset_again;
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule